// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block decides, for each incoming frame, whether the 48-bit destination address is one the station should take. It keeps a table of station addresses, each table slot gated by its own bit in an enable mask, and three mode switches: accept every unicast frame, accept every group (multicast) frame, and accept the all-ones broadcast address. The caller presents an address together with a one-cycle strobe; one clock later the block reports accept or reject, plus flags saying whether the acceptance was as multicast or as broadcast.

Slots are written one at a time through a load port that carries a slot index and three 16-bit words; the enable mask has its own write port. While the controller is held in reset, software can read back any slot as three 16-bit slices selected by a 4-bit pointer.

The rules are evaluated in a fixed priority order, and the first rule that passes decides the outcome and its flags. All slot comparisons run in parallel.

Top module: `addr_filter`

## Requirements
- R1: After reset, `resultValid` is low and the enable mask is zero, so no slot matches.
- R2: `resultValid` pulses high exactly one clock after `lookupStrobe`, and the result fields at that point reflect the address and mode bits sampled with the strobe.
- R3: With `modeUnicastAll` set, an address whose first byte (`lookupAddr[47:40]`) has bit 0 clear is accepted with both flags low.
- R4: With `modeMulticastAll` set, an address whose first byte has bit 0 set is accepted with `isMulticast` high and `isBroadcast` low.
- R5: With `modeBroadcast` set, the address 48'hFFFF_FFFF_FFFF is accepted with `isBroadcast` high and `isMulticast` low, unless R4 already accepted it (all-multicast has priority, so broadcast then reports multicast).
- R6: Slot i takes part in matching only when bit i of the enable mask is set; a full 48-bit match of an enabled slot accepts with both flags low.
- R7: A slot is loaded from three words; word k (k=0,1,2) supplies address bytes 2k (low byte of the word) and 2k+1 (high byte), where byte 0 is the first byte on the wire, i.e. `lookupAddr[47:40]`. Load and mask writes take effect on the next clock.
- R8: If no rule accepts, `accept` is low and both flags are low.
- R9: While `ctrlInReset` is high, `viewWord0..2` return words 0..2 of the slot chosen by `viewPtr[3:0]` in the same packing as R7; otherwise they read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadStrobe | input | 1 | Write one table slot |
| loadIndex | input | 4 | Slot to write |
| loadWord0 | input | 16 | Bytes 0 (low) and 1 (high) |
| loadWord1 | input | 16 | Bytes 2 (low) and 3 (high) |
| loadWord2 | input | 16 | Bytes 4 (low) and 5 (high) |
| maskStrobe | input | 1 | Write the enable mask |
| maskData | input | 16 | New enable mask |
| modeUnicastAll | input | 1 | Accept all unicast |
| modeMulticastAll | input | 1 | Accept all multicast |
| modeBroadcast | input | 1 | Accept broadcast |
| lookupStrobe | input | 1 | Address valid |
| lookupAddr | input | 48 | Destination address, first byte in [47:40] |
| resultValid | output | 1 | Decision valid |
| accept | output | 1 | Frame accepted |
| isMulticast | output | 1 | Accepted as multicast |
| isBroadcast | output | 1 | Accepted as broadcast |
| ctrlInReset | input | 1 | Controller held in reset; enables view port |
| viewPtr | input | 4 | Slot to view |
| viewWord0 | output | 16 | View slice 0 |
| viewWord1 | output | 16 | View slice 1 |
| viewWord2 | output | 16 | View slice 2 |

## Verification
The bench loads every slot with distinct addresses and sweeps every mode combination over unicast, multicast, broadcast, table-hit and miss addresses, so a design that let the unicast rule swallow multicast frames, or checked broadcast ahead of all-multicast, would show wrong flags. It walks the enable mask one bit at a time, catching a slot that matches while disabled or an off-by-one mask index. Byte-swapped packing within a load word shows up as misses on loaded addresses and wrong view slices, and a view port not gated by the reset input shows non-zero reads.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
  localparam int ENTRIES   = 16;
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int WORD_W    = 16;
  localparam int ADDR_W    = 48;
  localparam int WORDS     = ADDR_W / WORD_W;

  typedef struct packed {
    logic              loadEn;
    logic [IDX_W-1:0]  loadIdx;
    logic              maskEn;
    logic              lookupEn;
  } ctrlStrobes_t;

  typedef struct packed {
    logic accept;
    logic isMc;
    logic isBc;
  } decision_t;
endpackage

// File: rtl/addr_filter_ctrl.sv
module addr_filter_ctrl
  import addr_filter_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStrobe,
  input  logic [IDX_W-1:0] loadIndex,
  input  logic             maskStrobe,
  input  logic             lookupStrobe,
  output ctrlStrobes_t     strobes,
  output logic             resultValid
);
  always_comb begin
    strobes.loadEn   = loadStrobe;
    strobes.loadIdx  = loadIndex;
    strobes.maskEn   = maskStrobe;
    strobes.lookupEn = lookupStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= lookupStrobe;
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    lookupStrobe |=> resultValid);
  assert_valid_only_after_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupStrobe |=> !resultValid);
endmodule

// File: rtl/addr_filter_dp.sv
module addr_filter_dp
  import addr_filter_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [WORD_W-1:0]    loadWord0,
  input  logic [WORD_W-1:0]    loadWord1,
  input  logic [WORD_W-1:0]    loadWord2,
  input  logic [ENTRIES-1:0]   maskData,
  input  logic                 modeUnicastAll,
  input  logic                 modeMulticastAll,
  input  logic                 modeBroadcast,
  input  logic [ADDR_W-1:0]    lookupAddr,
  input  logic                 ctrlInReset,
  input  logic [IDX_W-1:0]     viewPtr,
  output decision_t            decision,
  output logic [WORD_W-1:0]    viewWord0,
  output logic [WORD_W-1:0]    viewWord1,
  output logic [WORD_W-1:0]    viewWord2
);
  logic [ADDR_W-1:0]  table_q [ENTRIES];
  logic [ENTRIES-1:0] enMask_q;
  logic [ENTRIES-1:0] hitVec;
  logic [ADDR_W-1:0]  loadAddr;
  decision_t          decisionNext;

  // Word k low byte is address byte 2k (earlier on wire, higher in vector).
  always_comb begin
    loadAddr = {loadWord0[7:0], loadWord0[15:8],
                loadWord1[7:0], loadWord1[15:8],
                loadWord2[7:0], loadWord2[15:8]};
  end

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) table_q[gi] <= '0;
        else if (strobes.loadEn && strobes.loadIdx == IDX_W'(gi))
          table_q[gi] <= loadAddr;
      end
      assign hitVec[gi] = enMask_q[gi] && (table_q[gi] == lookupAddr);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enMask_q <= '0;
    else if (strobes.maskEn) enMask_q <= maskData;
  end

  logic groupBit, allOnes;
  assign groupBit = lookupAddr[ADDR_W-8];
  assign allOnes  = &lookupAddr;

  always_comb begin
    decisionNext = '0;
    if (modeUnicastAll && !groupBit) begin
      decisionNext.accept = 1'b1;
    end else if (modeMulticastAll && groupBit) begin
      decisionNext.accept = 1'b1;
      decisionNext.isMc   = 1'b1;
    end else if (modeBroadcast && allOnes) begin
      decisionNext.accept = 1'b1;
      decisionNext.isBc   = 1'b1;
    end else if (|hitVec) begin
      decisionNext.accept = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) decision <= '0;
    else if (strobes.lookupEn) decision <= decisionNext;
  end

  logic [ADDR_W-1:0] viewAddr;
  assign viewAddr = table_q[viewPtr];
  always_comb begin
    if (ctrlInReset) begin
      viewWord0 = {viewAddr[39:32], viewAddr[47:40]};
      viewWord1 = {viewAddr[23:16], viewAddr[31:24]};
      viewWord2 = {viewAddr[7:0],   viewAddr[15:8]};
    end else begin
      viewWord0 = '0;
      viewWord1 = '0;
      viewWord2 = '0;
    end
  end

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(decision.isMc && decision.isBc));
  assert_flags_need_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (decision.isMc || decision.isBc) |-> decision.accept);
  assert_view_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlInReset |-> (viewWord0 == '0 && viewWord1 == '0 && viewWord2 == '0));
  assert_mc_tag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lookupEn && modeMulticastAll && groupBit) |=> (decision.accept && decision.isMc));
  assert_uc_all_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lookupEn && modeUnicastAll && !groupBit) |=> (decision.accept && !decision.isMc && !decision.isBc));
endmodule

// File: rtl/addr_filter.sv
module addr_filter
  import addr_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadStrobe,
  input  logic [3:0]  loadIndex,
  input  logic [15:0] loadWord0,
  input  logic [15:0] loadWord1,
  input  logic [15:0] loadWord2,
  input  logic        maskStrobe,
  input  logic [15:0] maskData,
  input  logic        modeUnicastAll,
  input  logic        modeMulticastAll,
  input  logic        modeBroadcast,
  input  logic        lookupStrobe,
  input  logic [47:0] lookupAddr,
  output logic        resultValid,
  output logic        accept,
  output logic        isMulticast,
  output logic        isBroadcast,
  input  logic        ctrlInReset,
  input  logic [3:0]  viewPtr,
  output logic [15:0] viewWord0,
  output logic [15:0] viewWord1,
  output logic [15:0] viewWord2
);
  ctrlStrobes_t strobes;
  decision_t    decision;

  addr_filter_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .loadIndex(loadIndex),
    .maskStrobe(maskStrobe), .lookupStrobe(lookupStrobe),
    .strobes(strobes), .resultValid(resultValid)
  );

  addr_filter_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .loadWord0(loadWord0), .loadWord1(loadWord1), .loadWord2(loadWord2),
    .maskData(maskData), .modeUnicastAll(modeUnicastAll),
    .modeMulticastAll(modeMulticastAll), .modeBroadcast(modeBroadcast),
    .lookupAddr(lookupAddr), .ctrlInReset(ctrlInReset), .viewPtr(viewPtr),
    .decision(decision), .viewWord0(viewWord0), .viewWord1(viewWord1),
    .viewWord2(viewWord2)
  );

  assign accept      = decision.accept;
  assign isMulticast = decision.isMc;
  assign isBroadcast = decision.isBc;
endmodule

// File: tb/test_addr_filter.sv
`timescale 1ns/1ps
module test_addr_filter;
  logic clk = 0, rstN = 0;
  always #2.5 clk = ~clk;

  logic loadStrobe = 0, maskStrobe = 0, lookupStrobe = 0;
  logic [3:0] loadIndex = 0, viewPtr = 0;
  logic [15:0] loadWord0 = 0, loadWord1 = 0, loadWord2 = 0, maskData = 0;
  logic mUc = 0, mMc = 0, mBc = 0, ctrlInReset = 0;
  logic [47:0] lookupAddr = 0;
  logic resultValid, accept, isMulticast, isBroadcast;
  logic [15:0] viewWord0, viewWord1, viewWord2;

  addr_filter i_addr_filter (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .loadIndex(loadIndex),
    .loadWord0(loadWord0), .loadWord1(loadWord1), .loadWord2(loadWord2),
    .maskStrobe(maskStrobe), .maskData(maskData),
    .modeUnicastAll(mUc), .modeMulticastAll(mMc), .modeBroadcast(mBc),
    .lookupStrobe(lookupStrobe), .lookupAddr(lookupAddr),
    .resultValid(resultValid), .accept(accept), .isMulticast(isMulticast),
    .isBroadcast(isBroadcast), .ctrlInReset(ctrlInReset), .viewPtr(viewPtr),
    .viewWord0(viewWord0), .viewWord1(viewWord1), .viewWord2(viewWord2)
  );

  int nChk = 0, nBad = 0;
  logic [47:0] refTab [16];
  logic [15:0] refMask = 0;

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] slotAddr(input int i);
    // unicast (first byte even), distinct per slot
    return {8'h02 + 8'(i*4), 8'h10, 8'h20, 8'h30, 8'(i), 8'h5A ^ 8'(i)};
  endfunction

  task automatic loadSlot(input int i, input logic [47:0] a);
    @(negedge clk);
    loadStrobe = 1; loadIndex = 4'(i);
    loadWord0 = {a[39:32], a[47:40]};
    loadWord1 = {a[23:16], a[31:24]};
    loadWord2 = {a[7:0], a[15:8]};
    @(negedge clk); loadStrobe = 0;
    refTab[i] = a;
  endtask

  task automatic setMask(input logic [15:0] m);
    @(negedge clk); maskStrobe = 1; maskData = m;
    @(negedge clk); maskStrobe = 0; refMask = m;
  endtask

  // reference model, from requirements
  function automatic logic [2:0] model(input logic [47:0] a, input logic u, input logic m, input logic b);
    if (u && !a[40]) return 3'b100;
    if (m && a[40]) return 3'b110;
    if (b && a == '1) return 3'b101;
    for (int i = 0; i < 16; i++) if (refMask[i] && refTab[i] == a) return 3'b100;
    return 3'b000;
  endfunction

  task automatic look(input string req, input logic [47:0] a, input logic u, input logic m, input logic b);
    logic [2:0] e;
    @(negedge clk);
    lookupStrobe = 1; lookupAddr = a; mUc = u; mMc = m; mBc = b;
    e = model(a, u, m, b);
    @(negedge clk);
    lookupStrobe = 0;
    chk({req, " valid R2"}, 48'(resultValid), 48'd1);
    chk(req, {45'd0, accept, isMulticast, isBroadcast}, {45'd0, e});
  endtask

  initial begin
    #200000;
    nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [47:0] probes [6];
    for (int i = 0; i < 16; i++) refTab[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 valid", 48'(resultValid), 0);
    chk("R1 accept", 48'(accept), 0);
    // R1: zero mask, zero address must not match a zero table
    look("R1 empty", 48'h0, 0, 0, 0);
    @(negedge clk);
    chk("R2 valid drops", 48'(resultValid), 0);

    for (int i = 0; i < 16; i++) loadSlot(i, slotAddr(i));
    // R9 view while in reset
    ctrlInReset = 1;
    for (int i = 0; i < 16; i++) begin
      viewPtr = 4'(i); #1;
      chk("R9 view0", 48'(viewWord0), 48'({refTab[i][39:32], refTab[i][47:40]}));
      chk("R9 view1", 48'(viewWord1), 48'({refTab[i][23:16], refTab[i][31:24]}));
      chk("R9 view2", 48'(viewWord2), 48'({refTab[i][7:0], refTab[i][15:8]}));
    end
    ctrlInReset = 0; #1;
    chk("R9 gated", {viewWord0, viewWord1, viewWord2}, 48'd0);

    // R6: walk mask one bit at a time
    for (int k = 0; k < 16; k++) begin
      setMask(16'(1) << k);
      for (int i = 0; i < 16; i++) look("R6 walk", slotAddr(i), 0, 0, 0);
    end
    setMask(16'hFFFF);
    // R7 on-next-clock: reload slot 3 and look immediately
    loadSlot(3, 48'h0A_BB_CC_DD_EE_F1);
    look("R7 reload", 48'h0A_BB_CC_DD_EE_F1, 0, 0, 0);
    look("R7 old gone", slotAddr(3), 0, 0, 0);

    // R3 R4 R5 R8 mode sweep
    probes[0] = 48'hFFFF_FFFF_FFFF;
    probes[1] = 48'h0100_5E00_0001;
    probes[2] = 48'h0200_0000_0099;
    probes[3] = slotAddr(7);
    probes[4] = 48'h0A_BB_CC_DD_EE_F1;
    probes[5] = 48'h0300_1122_3344;
    for (int md = 0; md < 8; md++)
      for (int p = 0; p < 6; p++)
        look("R3 R4 R5 R8 sweep", probes[p], md[2], md[1], md[0]);
    setMask(16'h0);
    look("R8 miss", slotAddr(7), 0, 0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule